// File: doc/BRIEF.md
# Conversion-start serial ADC host controller

This block drives a sampling converter that begins each conversion on the rising edge of a separate start line, and then reads the result over a serial link. A request from the system side latches a 6-bit configuration word and raises the start line. The controller then waits a fixed conversion time, counted in system clocks, and runs one 12-bit serial frame. During that frame it shifts the result in and shifts the latched configuration out. The converter applies that configuration to the conversion that follows.

The start line can behave in one of two ways, chosen by a parameter. In pulse mode it is high only for a short, fixed number of cycles. In hold mode it stays high for the whole conversion, which lets the converter sleep, and it falls only when the readout begins. The serial clock comes from the system clock through a divider and stays low between frames. After each frame the controller enforces an acquisition gap before it will accept the next request. It reports the result with a one-cycle done strobe and also gives a 16-bit copy of the result. That copy is sign-extended or zero-extended, depending on the format chosen for that conversion.

Top module: `sadc_ctl`

## Requirements
- R1: During and right after reset, `ready_o` is 1 and `conv_start_o`, `sclk_o` and `done_o` are 0.
- R2: A request is taken only while `ready_o` is 1, and `conv_start_o` rises on the next clock. A request made while the block is busy starts no conversion and does not change the configuration being sent.
- R3: In pulse mode (`HOLD_START`=0), `conv_start_o` stays high for exactly `START_HI` cycles. In hold mode it stays high for exactly `CONV_CYCLES` cycles and falls as the readout begins. It never falls at any other point.
- R4: The first rising edge of `sclk_o` comes no sooner than `CONV_CYCLES` system clocks after the rising edge of `conv_start_o`.
- R5: Each frame has exactly 12 rising edges of `sclk_o`, with a period of 2*`SCLK_HALF` system clocks. `sclk_o` is low whenever `ready_o` is 1.
- R6: `miso_i` is sampled on each rising edge of `sclk_o`, and the first bit sampled is the most significant bit of `result_o`.
- R7: `mosi_o` carries configuration bit 5 first, then bits 4 down to 0, then six zeros. It changes only after falling edges of `sclk_o`, so it is stable at every rising edge, and its first bit is present before the first rising edge.
- R8: `done_o` is high for exactly one clock per frame, and `result_o` holds the received word from that clock onward.
- R9: The result of a conversion uses the format set by bit 2 of the configuration sent in the frame before it. Bit 2 = 1 means unipolar, and `result_wide_o` is zero-extended. Bit 2 = 0 means bipolar, and `result_wide_o` is sign-extended. After reset the format is unipolar.
- R10: `ready_o` goes high exactly `ACQ_CYCLES` clocks after `done_o`. No start edge comes fewer than `ACQ_CYCLES` clocks after the last falling edge of `sclk_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request one conversion and readout |
| cfg_i | input | 6 | Configuration word sent during this readout |
| ready_o | output | 1 | Block idle and able to take a request |
| done_o | output | 1 | One-cycle strobe: result valid |
| result_o | output | 12 | Received result word |
| result_wide_o | output | 16 | Result extended according to its format |
| conv_start_o | output | 1 | Conversion start line to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| mosi_o | output | 1 | Configuration data to the converter |
| miso_i | input | 1 | Result data from the converter |

## Verification
On every cycle the assertions check the timing rules of the start line: its high width, the gap to the first serial clock edge, and the acquisition gap before the next start. They also check the 12-edge frame length, that `mosi_o` is stable at each rising edge, that the done strobe lasts one cycle, and that the extended result matches its low bits. Only the bench's scenarios can show the values themselves. That means the result shifted in MSB first, the exact configuration bit order seen by a converter model, the format carried over from the previous frame's bit 2, and that a request made while busy is ignored. The bench also runs both start-line modes, each on its own instance.

// File: rtl/sadc_ctl_pkg.sv
package sadc_ctl_pkg;

    // Configuration word, transmitted from the top bit down.
    typedef struct packed {
        logic se_diff_sel;   // bit 5, first on the wire
        logic odd_sign;      // bit 4
        logic chan_sel;      // bit 3
        logic unipolar;      // bit 2: 1 = straight binary, 0 = two's complement
        logic nap_req;       // bit 1
        logic spare;         // bit 0
    } sadc_cfg_t;

    localparam int CFG_BITS     = $bits(sadc_cfg_t);
    localparam int DEF_RES_W    = 12;
    localparam int DEF_WIDE_W   = 16;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_CONVERT = 2'd1,
        SEQ_SHIFT   = 2'd2,
        SEQ_ACQUIRE = 2'd3
    } seq_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sadc_ctl_seq.sv
module sadc_ctl_seq
    import sadc_ctl_pkg::*;
#(
    parameter int CONV_CYCLES = 400,
    parameter int ACQ_CYCLES  = 60,
    parameter int START_HI    = 5,
    parameter bit HOLD_START  = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic frame_last,
    output logic ready,
    output logic conv_start,
    output logic load_frame,
    output logic shift_en,
    output logic frame_done
);
    localparam int TMAX = max2(CONV_CYCLES, ACQ_CYCLES);
    localparam int TW   = $clog2(TMAX + 1);

    localparam logic [TW-1:0] CONV_LAST = TW'(CONV_CYCLES - 1);
    localparam logic [TW-1:0] ACQ_LAST  = TW'(ACQ_CYCLES - 1);
    localparam logic [TW-1:0] HI_LAST   = TW'(START_HI - 1);

    seq_state_e       state_q;
    logic [TW-1:0]    tmr_q;
    logic             start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            tmr_q   <= '0;
            start_q <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (req) begin
                        state_q <= SEQ_CONVERT;
                        tmr_q   <= '0;
                        start_q <= 1'b1;
                    end
                end
                SEQ_CONVERT: begin
                    tmr_q <= tmr_q + 1'b1;
                    if (!HOLD_START && tmr_q == HI_LAST) begin
                        start_q <= 1'b0;
                    end
                    if (tmr_q == CONV_LAST) begin
                        state_q <= SEQ_SHIFT;
                        start_q <= 1'b0;
                        tmr_q   <= '0;
                    end
                end
                SEQ_SHIFT: begin
                    tmr_q <= '0;
                    if (frame_last) begin
                        state_q <= SEQ_ACQUIRE;
                    end
                end
                SEQ_ACQUIRE: begin
                    tmr_q <= tmr_q + 1'b1;
                    if (tmr_q == ACQ_LAST) begin
                        state_q <= SEQ_IDLE;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign ready      = (state_q == SEQ_IDLE);
    assign conv_start = start_q;
    assign load_frame = (state_q == SEQ_CONVERT) && (tmr_q == CONV_LAST);
    assign shift_en   = (state_q == SEQ_SHIFT);
    assign frame_done = (state_q == SEQ_SHIFT) && frame_last;

endmodule

// File: rtl/sadc_ctl_clkdiv.sv
module sadc_ctl_clkdiv #(
    parameter int SCLK_HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic sclk,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int DW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam logic [DW-1:0] HALF_LAST = DW'(SCLK_HALF - 1);

    logic [DW-1:0] div_q;
    logic          sclk_q;
    logic          wrap;

    assign wrap      = en && (div_q == HALF_LAST);
    assign rise_tick = wrap && !sclk_q;
    assign fall_tick = wrap && sclk_q;
    assign sclk      = sclk_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            div_q  <= '0;
            sclk_q <= 1'b0;
        end else if (wrap) begin
            div_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            div_q  <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/sadc_ctl_shift.sv
module sadc_ctl_shift #(
    parameter int RES_W = 12,
    parameter int CFG_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CFG_W-1:0] cfg_bits,
    input  logic             rise_tick,
    input  logic             fall_tick,
    input  logic             miso,
    output logic             mosi,
    output logic [RES_W-1:0] rx_word,
    output logic             bits_done
);
    localparam int BW = $clog2(RES_W + 1);
    localparam logic [BW-1:0] BITS_ALL = BW'(RES_W);

    logic [RES_W-1:0] tx_q;
    logic [RES_W-1:0] rx_q;
    logic [RES_W-1:0] tx_init;
    logic [BW-1:0]    bits_q;

    generate
        if (RES_W > CFG_W) begin : g_pad
            assign tx_init = {cfg_bits, {(RES_W - CFG_W){1'b0}}};
        end else begin : g_trunc
            assign tx_init = cfg_bits[CFG_W-1 -: RES_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q   <= '0;
            rx_q   <= '0;
            bits_q <= '0;
        end else if (load) begin
            tx_q   <= tx_init;
            rx_q   <= '0;
            bits_q <= '0;
        end else begin
            if (rise_tick) begin
                rx_q   <= {rx_q[RES_W-2:0], miso};
                bits_q <= bits_q + 1'b1;
            end
            if (fall_tick) begin
                tx_q <= {tx_q[RES_W-2:0], 1'b0};
            end
        end
    end

    assign mosi      = tx_q[RES_W-1];
    assign rx_word   = rx_q;
    assign bits_done = (bits_q == BITS_ALL);

endmodule

// File: rtl/sadc_ctl.sv
module sadc_ctl
    import sadc_ctl_pkg::*;
#(
    parameter int RES_W       = DEF_RES_W,
    parameter int WIDE_W      = DEF_WIDE_W,
    parameter int SCLK_HALF   = 4,
    parameter int CONV_CYCLES = 400,
    parameter int ACQ_CYCLES  = 60,
    parameter int START_HI    = 5,
    parameter bit HOLD_START  = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_i,
    input  logic [CFG_BITS-1:0] cfg_i,
    output logic                ready_o,
    output logic                done_o,
    output logic [RES_W-1:0]    result_o,
    output logic [WIDE_W-1:0]   result_wide_o,
    output logic                conv_start_o,
    output logic                sclk_o,
    output logic                mosi_o,
    input  logic                miso_i
);
    localparam int EXT_W = WIDE_W - RES_W;

    logic             ready;
    logic             load_frame;
    logic             shift_en;
    logic             frame_done;
    logic             rise_tick;
    logic             fall_tick;
    logic             bits_done;
    logic [RES_W-1:0] rx_word;

    sadc_cfg_t        cfg_q;
    logic             fmt_uni_q;
    logic             done_q;
    logic [RES_W-1:0] result_q;
    logic [WIDE_W-1:0] wide_q;
    logic [WIDE_W-1:0] wide_d;

    sadc_ctl_seq #(
        .CONV_CYCLES (CONV_CYCLES),
        .ACQ_CYCLES  (ACQ_CYCLES),
        .START_HI    (START_HI),
        .HOLD_START  (HOLD_START)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .req        (req_i),
        .frame_last (fall_tick && bits_done),
        .ready      (ready),
        .conv_start (conv_start_o),
        .load_frame (load_frame),
        .shift_en   (shift_en),
        .frame_done (frame_done)
    );

    sadc_ctl_clkdiv #(
        .SCLK_HALF (SCLK_HALF)
    ) clkdiv_i (
        .clk       (clk),
        .rst       (rst),
        .en        (shift_en),
        .sclk      (sclk_o),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    sadc_ctl_shift #(
        .RES_W (RES_W),
        .CFG_W (CFG_BITS)
    ) shift_i (
        .clk       (clk),
        .rst       (rst),
        .load      (load_frame),
        .cfg_bits  (cfg_q),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .miso      (miso_i),
        .mosi      (mosi_o),
        .rx_word   (rx_word),
        .bits_done (bits_done)
    );

    // Extension for the word just received, using the format of its own conversion.
    generate
        if (EXT_W > 0) begin : g_ext
            assign wide_d = fmt_uni_q ? {{EXT_W{1'b0}}, rx_word}
                                      : {{EXT_W{rx_word[RES_W-1]}}, rx_word};
        end else begin : g_noext
            assign wide_d = rx_word[WIDE_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            fmt_uni_q <= 1'b1;
            done_q    <= 1'b0;
            result_q  <= '0;
            wide_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (req_i && ready) begin
                cfg_q <= sadc_cfg_t'(cfg_i);
            end
            if (frame_done) begin
                done_q    <= 1'b1;
                result_q  <= rx_word;
                wide_q    <= wide_d;
                fmt_uni_q <= cfg_q.unipolar;   // applies to the next conversion
            end
        end
    end

    assign ready_o       = ready;
    assign done_o        = done_q;
    assign result_o      = result_q;
    assign result_wide_o = wide_q;

endmodule

// File: rtl/sadc_ctl_chk.sv
module sadc_ctl_chk #(
    parameter int RES_W       = 12,
    parameter int WIDE_W      = 16,
    parameter int CONV_CYCLES = 400,
    parameter int ACQ_CYCLES  = 60,
    parameter int START_HI    = 5,
    parameter bit HOLD_START  = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              ready_o,
    input logic              done_o,
    input logic [RES_W-1:0]  result_o,
    input logic [WIDE_W-1:0] result_wide_o,
    input logic              conv_start_o,
    input logic              sclk_o,
    input logic              mosi_o
);
    localparam int SAT = 32'h3fff_ffff;

    logic start_d, sclk_d;
    int   hi_cnt, since_start, since_fall, rise_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_d     <= 1'b0;
            sclk_d      <= 1'b0;
            hi_cnt      <= 0;
            since_start <= SAT;
            since_fall  <= ACQ_CYCLES;
            rise_cnt    <= 0;
        end else begin
            start_d <= conv_start_o;
            sclk_d  <= sclk_o;
            hi_cnt  <= conv_start_o ? ((hi_cnt < SAT) ? hi_cnt + 1 : hi_cnt) : 0;
            if (conv_start_o && !start_d) since_start <= 1;
            else if (since_start < SAT)   since_start <= since_start + 1;
            if (sclk_d && !sclk_o)        since_fall <= 1;
            else if (since_fall < SAT)    since_fall <= since_fall + 1;
            if (conv_start_o && !start_d) rise_cnt <= 0;
            else if (sclk_o && !sclk_d)   rise_cnt <= rise_cnt + 1;
        end
    end

    // R2
    start_gated_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_start_o) |-> $past(ready_o));

    // R3
    start_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(conv_start_o) |-> (HOLD_START ? (hi_cnt == CONV_CYCLES) : (hi_cnt == START_HI)));

    // R4
    conv_wait_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_o) |-> (since_start >= CONV_CYCLES));

    // R5
    frame_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> (rise_cnt == RES_W));

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> (!sclk_o && !conv_start_o));

    // R7
    mosi_stable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_o) |-> $stable(mosi_o));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9
    wide_match_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (result_wide_o[RES_W-1:0] == result_o &&
                    (result_wide_o[WIDE_W-1:RES_W] == '0 ||
                     (result_wide_o[WIDE_W-1:RES_W] == '1 && result_o[RES_W-1]))));

    // R10
    acq_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_start_o) |-> (since_fall >= ACQ_CYCLES));

endmodule

bind sadc_ctl sadc_ctl_chk #(
    .RES_W       (RES_W),
    .WIDE_W      (WIDE_W),
    .CONV_CYCLES (CONV_CYCLES),
    .ACQ_CYCLES  (ACQ_CYCLES),
    .START_HI    (START_HI),
    .HOLD_START  (HOLD_START)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .ready_o       (ready_o),
    .done_o        (done_o),
    .result_o      (result_o),
    .result_wide_o (result_wide_o),
    .conv_start_o  (conv_start_o),
    .sclk_o        (sclk_o),
    .mosi_o        (mosi_o)
);

// File: tb/sadc_ctl_tb_top.sv
`timescale 1ns/1ps

module adc_conv_model #(
    parameter int TCONV = 325
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cnv,
    input  logic        sclk,
    input  logic        sdi,
    input  logic [11:0] word,
    output logic        sdo,
    output logic [11:0] cfg_seen,
    output int          rises,
    output int          starts,
    output int          hi_width,
    output int          first_rise_age
);
    logic cnv_d, sclk_d;
    int   age, hi, fcnt;

    always @(posedge clk) begin
        if (rst) begin
            cnv_d <= 1'b0; sclk_d <= 1'b0; age <= 0; hi <= 0; fcnt <= 12;
            cfg_seen <= '0; rises <= 0; starts <= 0; hi_width <= 0; first_rise_age <= 0;
        end else begin
            cnv_d  <= cnv;
            sclk_d <= sclk;
            if (cnv && !cnv_d) begin
                age <= 1; starts <= starts + 1; rises <= 0; fcnt <= 0;
            end else begin
                age <= age + 1;
            end
            hi <= cnv ? hi + 1 : 0;
            if (!cnv && cnv_d) hi_width <= hi;
            if (sclk && !sclk_d) begin
                if (rises == 0) first_rise_age <= age;
                rises    <= rises + 1;
                cfg_seen <= {cfg_seen[10:0], sdi};
            end
            if (!sclk && sclk_d && fcnt < 12) fcnt <= fcnt + 1;
        end
    end

    // Data is unknown until the conversion is over and the start line is low.
    assign sdo = (!cnv && age >= TCONV && fcnt < 12) ? word[11 - fcnt] : 1'bx;
endmodule

module sadc_ctl_tb_top;
    localparam int CONV  = 400;
    localparam int ACQ   = 60;
    localparam int HALF  = 4;
    localparam int HI    = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        req [2];
    logic [5:0]  cfg [2];
    logic [11:0] word [2];
    logic        ready [2];
    logic        done [2];
    logic [11:0] res [2];
    logic [15:0] wide [2];
    logic        cnv [2];
    logic        sclk [2];
    logic        mosi [2];
    logic        miso [2];
    logic [11:0] cfg_seen [2];
    int          rises [2];
    int          starts [2];
    int          hi_width [2];
    int          first_age [2];
    bit          exp_uni [2];

    int n_checks = 0;
    int n_errors = 0;

    sadc_ctl #(.SCLK_HALF(HALF), .CONV_CYCLES(CONV), .ACQ_CYCLES(ACQ),
               .START_HI(HI), .HOLD_START(1'b0)) dut_i (
        .clk(clk), .rst(rst), .req_i(req[0]), .cfg_i(cfg[0]), .ready_o(ready[0]),
        .done_o(done[0]), .result_o(res[0]), .result_wide_o(wide[0]),
        .conv_start_o(cnv[0]), .sclk_o(sclk[0]), .mosi_o(mosi[0]), .miso_i(miso[0]));

    sadc_ctl #(.SCLK_HALF(HALF), .CONV_CYCLES(CONV), .ACQ_CYCLES(ACQ),
               .START_HI(HI), .HOLD_START(1'b1)) dut_sleep_i (
        .clk(clk), .rst(rst), .req_i(req[1]), .cfg_i(cfg[1]), .ready_o(ready[1]),
        .done_o(done[1]), .result_o(res[1]), .result_wide_o(wide[1]),
        .conv_start_o(cnv[1]), .sclk_o(sclk[1]), .mosi_o(mosi[1]), .miso_i(miso[1]));

    adc_conv_model model0_i (.clk(clk), .rst(rst), .cnv(cnv[0]), .sclk(sclk[0]), .sdi(mosi[0]),
        .word(word[0]), .sdo(miso[0]), .cfg_seen(cfg_seen[0]), .rises(rises[0]),
        .starts(starts[0]), .hi_width(hi_width[0]), .first_rise_age(first_age[0]));

    adc_conv_model model1_i (.clk(clk), .rst(rst), .cnv(cnv[1]), .sclk(sclk[1]), .sdi(mosi[1]),
        .word(word[1]), .sdo(miso[1]), .cfg_seen(cfg_seen[1]), .rises(rises[1]),
        .starts(starts[1]), .hi_width(hi_width[1]), .first_rise_age(first_age[1]));

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", rq, what, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // R1: reset state on both instances
    task automatic test_reset();
        for (int u = 0; u < 2; u++) begin
            check(ready[u] === 1'b1, "R1", "ready after reset", 32'(ready[u]), 1);
            check(cnv[u] === 1'b0,   "R1", "start line after reset", 32'(cnv[u]), 0);
            check(sclk[u] === 1'b0,  "R1", "sclk after reset", 32'(sclk[u]), 0);
            check(done[u] === 1'b0,  "R1", "done after reset", 32'(done[u]), 0);
        end
    endtask

    // One full conversion; poke=1 also fires a request while busy (R2).
    task automatic run_conv(input int u, input logic [5:0] c, input logic [11:0] w, input bit poke);
        int n;
        int starts0;
        logic [15:0] exp_wide;
        word[u] = w;
        n = 0;
        while (ready[u] !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
        starts0 = starts[u];
        req[u] = 1'b1; cfg[u] = c;
        @(negedge clk);
        req[u] = 1'b0;
        check(cnv[u] === 1'b1 && ready[u] === 1'b0, "R2", "start rises after request",
              32'({cnv[u], ready[u]}), 32'b10);
        n = 0;
        while (done[u] !== 1'b1 && n < 5000) begin
            @(negedge clk); n++;
            if (poke && n == 50) begin req[u] = 1'b1; cfg[u] = ~c; end
            if (poke && n == 52) begin req[u] = 1'b0; cfg[u] = c; end
        end
        check(n < 5000, "R8", "done seen", 32'(n), 0);
        exp_wide = exp_uni[u] ? {4'h0, w} : {{4{w[11]}}, w};
        check(res[u] === w, "R6", "result word", 32'(res[u]), 32'(w));
        check(wide[u] === exp_wide, "R9", "extended result", 32'(wide[u]), 32'(exp_wide));
        check(cfg_seen[u] === {c, 6'b0}, "R7", "bits seen by converter",
              32'(cfg_seen[u]), 32'({c, 6'b0}));
        check(rises[u] == 12, "R5", "sclk rising edges in frame", 32'(rises[u]), 12);
        check(hi_width[u] == (u == 1 ? CONV : HI), "R3", "start line high width",
              32'(hi_width[u]), 32'(u == 1 ? CONV : HI));
        check(first_age[u] >= CONV, "R4", "cycles from start to first sclk rise",
              32'(first_age[u]), CONV);
        check(starts[u] - starts0 == 1, "R2", "start edges for one request",
              32'(starts[u] - starts0), 1);
        exp_uni[u] = c[2];
        n = 1;
        @(negedge clk);
        check(done[u] === 1'b0, "R8", "done width one cycle", 32'(done[u]), 0);
        check(res[u] === w, "R8", "result held after done", 32'(res[u]), 32'(w));
        while (ready[u] !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
        check(n == ACQ, "R10", "cycles from done to ready", 32'(n), ACQ);
        check(sclk[u] === 1'b0, "R5", "sclk idle low", 32'(sclk[u]), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary_and_end();
    end

    initial begin
        for (int u = 0; u < 2; u++) begin
            req[u] = 1'b0; cfg[u] = '0; word[u] = '0; exp_uni[u] = 1'b1;
        end
        repeat (4) @(negedge clk);
        test_reset();
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        // R9: first result uses the reset format (unipolar), next cfg picks bipolar
        run_conv(0, 6'b100_100, 12'hA5C, 1'b0);
        run_conv(0, 6'b010_001, 12'h3F1, 1'b0);
        // negative bipolar result, sign-extended
        run_conv(0, 6'b111_100, 12'h8F0, 1'b0);
        run_conv(0, 6'b001_010, 12'h7FF, 1'b0);
        // positive bipolar result; request while busy is ignored (R2)
        run_conv(0, 6'b110_110, 12'h123, 1'b1);
        // hold-mode instance (R3)
        run_conv(1, 6'b101_000, 12'hC3A, 1'b0);
        run_conv(1, 6'b011_100, 12'h801, 1'b0);
        summary_and_end();
    end
endmodule